// File: doc/BRIEF.md
# Wide Bit-Vector Coprocessor Datapath

This block is the execution core of a bit-vector coprocessor. It holds a bank of wide vector registers, separate from any integer register file, and applies one gate-style operation per cycle to up to three source registers. The operations are plain AND, OR and XOR, in-place controlled operations (controlled NOT, Toffoli, and a per-bit Fredkin swap), whole-register NOT, ONE and ZERO, and a pattern initializer. Swap-type operations write two registers in the same cycle.

A decoder upstream presents an already decoded opcode, three register indices, a 4-bit immediate and a valid strobe. The bank is read combinationally and written on the rising edge. The data written by each write port and its write flag are registered and driven on the outputs. Reading a register therefore only needs an OR of that register with itself into a spare register. The pattern initializer fills a register with blocks of 2^n ones placed above 2^n zeros, repeated across the full width. Bits are numbered from bit 0 as the least significant.

Top module: `vbit_alu`

## Requirements
- R1: With valid high, AND, OR and XOR (opcodes 1, 2, 3) write register a with b&c, b|c and b^c. The value written appears on res_a_o, with wr_a_o high, one cycle later.
- R2: CCNOT (opcode 4) writes a^(b&c) to a. CNOT (opcode 5) writes a^b to a. NOT (opcode 6) writes ~a to a.
- R3: SWAP (opcode 7) writes the old b into a and the old a into b in one cycle. res_a_o shows the new a, res_b_o shows the new b, and both wr_a_o and wr_b_o are high. wr_b_o is high only after SWAP or CSWAP.
- R4: CSWAP (opcode 8) works per bit. Where c is 1, a and b exchange that bit. Where c is 0, both keep it.
- R5: The pattern initializer (opcode 9) with immediate n below log2(WIDTH) writes a with bit i equal to bit n of the number i. For example n=0 gives ...1010, and n=log2(WIDTH)-1 gives the upper half set.
- R6: The pattern initializer with n at or above log2(WIDTH) writes all zeros and raises bad_imm_o for that one cycle only.
- R7: ONE (opcode 10) writes all ones to a. ZERO (opcode 11) writes all zeros to a.
- R8: When both write ports target the same register, port A wins. SWAP or CSWAP of a register with itself leaves that register unchanged.
- R9: With valid low, no register is written and wr_a_o, wr_b_o and bad_imm_o are low, whatever the opcode.
- R10: Synchronous active-high reset clears res_a_o, res_b_o, wr_a_o, wr_b_o and bad_imm_o.
- R11: An operation changes only its own destination registers. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Decoded opcode |
| idx_a_i | input | IDX_W | Destination and first source index |
| idx_b_i | input | IDX_W | Second source index, second destination for swaps |
| idx_c_i | input | IDX_W | Third source (control) index |
| imm_i | input | 4 | Pattern immediate |
| res_a_o | output | WIDTH | Registered data from write port A |
| res_b_o | output | WIDTH | Registered data from write port B |
| wr_a_o | output | 1 | Port A wrote last cycle |
| wr_b_o | output | 1 | Port B wrote last cycle |
| bad_imm_o | output | 1 | Last operation was a pattern load with an out-of-range immediate |

## Verification
The bench builds the block with WIDTH=32 and NREG=16. With these values every expected vector fits in eight hex digits, and the legal/illegal immediate boundary falls at n=5. Immediates 4, 5 and 15 therefore cover the last legal pattern, the first illegal one and the largest code. The smaller bank also lets the bench use every index. One register serves as a scratch target for read-back after swaps and self-swaps.

// File: rtl/vbit_pkg.sv
package vbit_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_CCNOT = 4'd4,
    OP_CNOT  = 4'd5,
    OP_NOT   = 4'd6,
    OP_SWAP  = 4'd7,
    OP_CSWAP = 4'd8,
    OP_PAT   = 4'd9,
    OP_ONE   = 4'd10,
    OP_ZERO  = 4'd11
  } vbit_op_e;

  localparam int IMM_W = 4;
endpackage

// File: rtl/vbit_patgen.sv
module vbit_patgen #(
  parameter int WIDTH = 256
) (
  input  logic [vbit_pkg::IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0]           pat_o,
  output logic                       bad_o
);
  localparam int LOG_W = $clog2(WIDTH);

  assign bad_o = ({28'd0, imm_i} >= LOG_W);

  // bit i of the pattern is bit n of the position number i
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic [31:0] POS = i;
    logic [31:0] shifted;
    assign shifted  = POS >> imm_i;
    assign pat_o[i] = !bad_o && shifted[0];
  end
endmodule

// File: rtl/vbit_opunit.sv
module vbit_opunit #(
  parameter int WIDTH = 256
) (
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] va_i,
  input  logic [WIDTH-1:0] vb_i,
  input  logic [WIDTH-1:0] vc_i,
  input  logic [WIDTH-1:0] pat_i,
  output logic [WIDTH-1:0] da_o,
  output logic [WIDTH-1:0] db_o,
  output logic             we_a_o,
  output logic             we_b_o
);
  import vbit_pkg::*;

  always_comb begin
    da_o   = '0;
    db_o   = '0;
    we_a_o = 1'b0;
    we_b_o = 1'b0;
    if (valid_i) begin
      case (vbit_op_e'(op_i))
        OP_AND:   begin da_o = vb_i & vc_i;          we_a_o = 1'b1; end
        OP_OR:    begin da_o = vb_i | vc_i;          we_a_o = 1'b1; end
        OP_XOR:   begin da_o = vb_i ^ vc_i;          we_a_o = 1'b1; end
        OP_CCNOT: begin da_o = va_i ^ (vb_i & vc_i); we_a_o = 1'b1; end
        OP_CNOT:  begin da_o = va_i ^ vb_i;          we_a_o = 1'b1; end
        OP_NOT:   begin da_o = ~va_i;                we_a_o = 1'b1; end
        OP_SWAP: begin
          da_o   = vb_i;
          db_o   = va_i;
          we_a_o = 1'b1;
          we_b_o = 1'b1;
        end
        OP_CSWAP: begin
          da_o   = (vc_i & vb_i) | (~vc_i & va_i);
          db_o   = (vc_i & va_i) | (~vc_i & vb_i);
          we_a_o = 1'b1;
          we_b_o = 1'b1;
        end
        OP_PAT:   begin da_o = pat_i; we_a_o = 1'b1; end
        OP_ONE:   begin da_o = '1;    we_a_o = 1'b1; end
        OP_ZERO:  begin da_o = '0;    we_a_o = 1'b1; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vbit_regfile.sv
module vbit_regfile #(
  parameter int WIDTH = 256,
  parameter int NREG  = 256,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  input  logic [IDX_W-1:0] rc_i,
  output logic [WIDTH-1:0] qa_o,
  output logic [WIDTH-1:0] qb_o,
  output logic [WIDTH-1:0] qc_o,
  input  logic             we_a_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [WIDTH-1:0] da_i,
  input  logic             we_b_i,
  input  logic [IDX_W-1:0] wb_i,
  input  logic [WIDTH-1:0] db_i
);
  logic [WIDTH-1:0] mem [NREG];

  assign qa_o = mem[ra_i];
  assign qb_o = mem[rb_i];
  assign qc_o = mem[rc_i];

  // port A is written last so it wins on a shared target
  always_ff @(posedge clk) begin
    if (we_b_i) mem[wb_i] <= db_i;
    if (we_a_i) mem[wa_i] <= da_i;
  end
endmodule

// File: rtl/vbit_alu.sv
module vbit_alu #(
  parameter int WIDTH = 256,
  parameter int NREG  = 256,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [IDX_W-1:0] idx_b_i,
  input  logic [IDX_W-1:0] idx_c_i,
  input  logic [3:0]       imm_i,
  output logic [WIDTH-1:0] res_a_o,
  output logic [WIDTH-1:0] res_b_o,
  output logic             wr_a_o,
  output logic             wr_b_o,
  output logic             bad_imm_o
);
  import vbit_pkg::*;

  logic [WIDTH-1:0] va, vb, vc, pat, da, db;
  logic             we_a, we_b, pat_bad;

  vbit_regfile #(.WIDTH(WIDTH), .NREG(NREG)) u_rf (
    .clk(clk),
    .ra_i(idx_a_i), .rb_i(idx_b_i), .rc_i(idx_c_i),
    .qa_o(va), .qb_o(vb), .qc_o(vc),
    .we_a_i(we_a), .wa_i(idx_a_i), .da_i(da),
    .we_b_i(we_b), .wb_i(idx_b_i), .db_i(db)
  );

  vbit_patgen #(.WIDTH(WIDTH)) u_pat (
    .imm_i(imm_i), .pat_o(pat), .bad_o(pat_bad)
  );

  vbit_opunit #(.WIDTH(WIDTH)) u_op (
    .valid_i(valid_i), .op_i(op_i),
    .va_i(va), .vb_i(vb), .vc_i(vc), .pat_i(pat),
    .da_o(da), .db_o(db), .we_a_o(we_a), .we_b_o(we_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a_o   <= '0;
      res_b_o   <= '0;
      wr_a_o    <= 1'b0;
      wr_b_o    <= 1'b0;
      bad_imm_o <= 1'b0;
    end else begin
      res_a_o   <= da;
      res_b_o   <= db;
      wr_a_o    <= we_a;
      wr_b_o    <= we_b;
      bad_imm_o <= valid_i && (op_i == OP_PAT) && pat_bad;
    end
  end
endmodule

// File: rtl/vbit_alu_chk.sv
module vbit_alu_chk #(
  parameter int WIDTH = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_a_o,
  input logic             wr_a_o,
  input logic             wr_b_o,
  input logic             bad_imm_o
);
  import vbit_pkg::*;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(valid_i)) |-> (!wr_a_o && !wr_b_o && !bad_imm_o));

  p_port_b_swaps_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wr_b_o) |-> ($past(op_i) == OP_SWAP || $past(op_i) == OP_CSWAP));

  p_bad_imm_zero_r6: assert property (@(posedge clk) disable iff (rst)
    bad_imm_o |-> (wr_a_o && res_a_o == '0));

  p_one_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(valid_i) && $past(op_i) == OP_ONE) |-> (wr_a_o && res_a_o == '1));

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(valid_i) && $past(op_i) == OP_ZERO) |-> (wr_a_o && res_a_o == '0));

  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!wr_a_o && !wr_b_o && !bad_imm_o));
endmodule

bind vbit_alu vbit_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
  .res_a_o(res_a_o), .wr_a_o(wr_a_o), .wr_b_o(wr_b_o), .bad_imm_o(bad_imm_o)
);

// File: tb/vbit_alu_test.sv
module vbit_alu_test;
  import vbit_pkg::*;

  localparam int W  = 32;
  localparam int NR = 16;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [IW-1:0] ia = '0, ib = '0, ic = '0;
  logic [3:0] imm = 4'd0;
  logic [W-1:0] ra, rb;
  logic wa, wb, bad;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vbit_alu #(.WIDTH(W), .NREG(NR)) uut (
    .clk(clk), .rst(rst), .valid_i(valid), .op_i(op),
    .idx_a_i(ia), .idx_b_i(ib), .idx_c_i(ic), .imm_i(imm),
    .res_a_o(ra), .res_b_o(rb), .wr_a_o(wa), .wr_b_o(wb), .bad_imm_o(bad)
  );

  typedef struct packed {
    vbit_op_e     op;
    logic [3:0]   a, b, c, n;
    logic [W-1:0] ea, eb;
    logic         ewa, ewb, ebad;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{OP_PAT,   4'd1, 4'd0, 4'd0, 4'd0,  32'hAAAAAAAA, 32'h0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5
    '{OP_PAT,   4'd2, 4'd0, 4'd0, 4'd1,  32'hCCCCCCCC, 32'h0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5
    '{OP_PAT,   4'd3, 4'd0, 4'd0, 4'd4,  32'hFFFF0000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 last legal
    '{OP_PAT,   4'd4, 4'd0, 4'd0, 4'd5,  32'h00000000, 32'h0, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 first illegal
    '{OP_PAT,   4'd5, 4'd0, 4'd0, 4'd15, 32'h00000000, 32'h0, 1'b1, 1'b0, 1'b1, 8'd6},  // R6
    '{OP_ONE,   4'd6, 4'd0, 4'd0, 4'd0,  32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7, R6 flag drops
    '{OP_ZERO,  4'd7, 4'd0, 4'd0, 4'd0,  32'h00000000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7
    '{OP_AND,   4'd8, 4'd1, 4'd2, 4'd0,  32'h88888888, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1},  // R1
    '{OP_OR,    4'd9, 4'd1, 4'd2, 4'd0,  32'hEEEEEEEE, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1},  // R1
    '{OP_XOR,   4'd10, 4'd1, 4'd2, 4'd0, 32'h66666666, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1},  // R1
    '{OP_CCNOT, 4'd10, 4'd1, 4'd3, 4'd0, 32'hCCCC6666, 32'h0, 1'b1, 1'b0, 1'b0, 8'd2},  // R2
    '{OP_CNOT,  4'd10, 4'd2, 4'd0, 4'd0, 32'h0000AAAA, 32'h0, 1'b1, 1'b0, 1'b0, 8'd2},  // R2
    '{OP_NOT,   4'd10, 4'd0, 4'd0, 4'd0, 32'hFFFF5555, 32'h0, 1'b1, 1'b0, 1'b0, 8'd2},  // R2
    '{OP_SWAP,  4'd1, 4'd2, 4'd0, 4'd0,  32'hCCCCCCCC, 32'hAAAAAAAA, 1'b1, 1'b1, 1'b0, 8'd3}, // R3
    '{OP_OR,    4'd15, 4'd1, 4'd1, 4'd0, 32'hCCCCCCCC, 32'h0, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 readback
    '{OP_OR,    4'd15, 4'd2, 4'd2, 4'd0, 32'hAAAAAAAA, 32'h0, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 readback
    '{OP_CSWAP, 4'd1, 4'd2, 4'd3, 4'd0,  32'hAAAACCCC, 32'hCCCCAAAA, 1'b1, 1'b1, 1'b0, 8'd4}, // R4
    '{OP_OR,    4'd15, 4'd2, 4'd2, 4'd0, 32'hCCCCAAAA, 32'h0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 readback
    '{OP_SWAP,  4'd6, 4'd6, 4'd0, 4'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 8'd8}, // R8
    '{OP_OR,    4'd15, 4'd6, 4'd6, 4'd0, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 readback
    '{OP_CSWAP, 4'd9, 4'd9, 4'd3, 4'd0,  32'hEEEEEEEE, 32'hEEEEEEEE, 1'b1, 1'b1, 1'b0, 8'd8}, // R8
    '{OP_OR,    4'd15, 4'd8, 4'd8, 4'd0, 32'h88888888, 32'h0, 1'b1, 1'b0, 1'b0, 8'd11}, // R11
    '{OP_OR,    4'd15, 4'd3, 4'd3, 4'd0, 32'hFFFF0000, 32'h0, 1'b1, 1'b0, 1'b0, 8'd11}  // R11
  };

  task automatic check(input string what, input int req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge register the result, sample at next negedge
  task automatic run_op(input logic v, input vbit_op_e o, input logic [3:0] a,
                        input logic [3:0] b, input logic [3:0] c, input logic [3:0] n);
    valid = v; op = o; ia = a[IW-1:0]; ib = b[IW-1:0]; ic = c[IW-1:0]; imm = n;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("reset wr_a", 10, {31'd0, wa}, 32'd0);
    check("reset wr_b", 10, {31'd0, wb}, 32'd0);
    check("reset bad_imm", 10, {31'd0, bad}, 32'd0);
    check("reset res_a", 10, ra, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_op(1'b1, TBL[k].op, TBL[k].a, TBL[k].b, TBL[k].c, TBL[k].n);
      check($sformatf("vec %0d res_a", k), int'(TBL[k].req), ra, TBL[k].ea);
      check($sformatf("vec %0d wr_a", k), int'(TBL[k].req), {31'd0, wa}, {31'd0, TBL[k].ewa});
      check($sformatf("vec %0d wr_b", k), int'(TBL[k].req), {31'd0, wb}, {31'd0, TBL[k].ewb});
      check($sformatf("vec %0d bad_imm", k), int'(TBL[k].req), {31'd0, bad}, {31'd0, TBL[k].ebad});
      if (TBL[k].ewb)
        check($sformatf("vec %0d res_b", k), int'(TBL[k].req), rb, TBL[k].eb);
    end

    // R9: ZERO on r8 with valid low, then illegal pattern with valid low
    run_op(1'b0, OP_ZERO, 4'd8, 4'd0, 4'd0, 4'd0);
    check("idle wr_a", 9, {31'd0, wa}, 32'd0);
    run_op(1'b0, OP_PAT, 4'd8, 4'd0, 4'd0, 4'd9);
    check("idle bad_imm", 9, {31'd0, bad}, 32'd0);
    run_op(1'b1, OP_OR, 4'd15, 4'd8, 4'd8, 4'd0);
    check("idle r8 kept", 9, ra, 32'h88888888);

    // R8: swap then self-swap sequence keeps r10 (FFFF5555) intact
    run_op(1'b1, OP_SWAP, 4'd10, 4'd10, 4'd0, 4'd0);
    run_op(1'b1, OP_OR, 4'd15, 4'd10, 4'd10, 4'd0);
    check("self swap r10", 8, ra, 32'hFFFF5555);

    // R2: CNOT of a register with itself clears it
    run_op(1'b1, OP_CNOT, 4'd6, 4'd6, 4'd0, 4'd0);
    check("cnot self", 2, ra, 32'h00000000);

    // R10: reset mid-run clears outputs
    valid = 1'b1; op = OP_ONE; ia = 4'd7; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; rst = 1'b0;
    check("mid reset res_a", 10, ra, 32'd0);
    check("mid reset wr_a", 10, {31'd0, wa}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule